// File: doc/BRIEF.md
# Count-Pulse Timer Counter Unit

This unit keeps four software-visible counters that advance on timing pulses rather than on every clock. Each channel picks its own pulse source: a mains-rate pulse, a 500 Hz tick, a 2000 Hz tick, or an external pulse line. The fourth channel is tied to the 500 Hz tick. Both ticks are derived on chip by dividing the system clock. The two outside pulse lines are asynchronous. They are synchronised and edge-detected, so each rising edge produces exactly one pulse.

On every pulse of a channel whose operation is set to modify-and-test, a signed byte is sign-extended and added to the low byte, halfword or word of that channel's counter. The bits above the chosen width keep their value. When the bits at the chosen width come out zero, the channel raises a one-cycle counter-equals-zero request for a downstream interrupt arbiter. The fourth channel accepts only the modify-and-test operation; a pulse on it while another operation is configured raises an illegal-operation flag. A load port per channel overwrites the counter, and a load beats a pulse arriving in the same cycle.

Top module: `ctp_timer_unit`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, every counter reads zero, and `pulse_o`, `zero_req_o` and `illegal_op_o` are all low.
- R2: Channel index 3 pulses once every `CLK_PER_500` clock cycles regardless of any select input, and each pulse lasts one cycle.
- R3: Channels 0 to 2 take their pulse from a 2-bit select: 0 = line input, 1 = 500 Hz tick (period `CLK_PER_500`), 2 = 2000 Hz tick (period `CLK_PER_500/4`), 3 = external input. Each pulse lasts one cycle.
- R4: Each rising edge of `line_pulse_i` or `ext_pulse_i` gives exactly one pulse to the channels that select it. When the input is set up before clock edge e0, that pulse is visible between edge e1 and edge e2.
- R5: The width select per channel uses 0 = byte (bits 7:0), 1 = halfword (bits 15:0), 2 or 3 = word (bits 31:0). A pulse changes only the bits inside that width. Without a pulse or a load, the counter holds its value.
- R6: The modify value is a signed 8-bit number. It is sign-extended and added modulo 2^width, so it wraps within the chosen width.
- R7: `zero_req_o` of a channel is high for exactly one cycle when a pulse-driven update leaves the chosen width all zero. The request appears together with the updated counter value, on the cycle after the pulse.
- R8: A load writes the full counter on the next edge. If a pulse arrives in the same cycle, the load wins. A load never raises a zero request.
- R9: Operation bit 1 = modify-and-test and 0 = other. With 0, pulses leave the counter unchanged. If channel 3 gets a pulse while its operation bit is 0, `illegal_op_o` goes high for one cycle on the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pulse_i | input | 1 | Asynchronous mains-rate pulse |
| ext_pulse_i | input | 1 | Asynchronous user pulse |
| src_sel_i | input | 6 | 2-bit source select for channels 0..2 (channel n at bits 2n+1:2n) |
| width_sel_i | input | 8 | 2-bit operand width per channel |
| op_mt_i | input | 4 | Per-channel modify-and-test enable |
| mod_val_i | input | 32 | Signed byte modify value per channel |
| load_en_i | input | 4 | Per-channel counter load strobe |
| load_val_i | input | 128 | Load value, 32 bits per channel |
| count_o | output | 128 | Counter values, 32 bits per channel |
| pulse_o | output | 4 | Per-channel count-pulse strobe |
| zero_req_o | output | 4 | Per-channel counter-equals-zero request |
| illegal_op_o | output | 1 | Illegal operation on channel 3 |

## Verification
The bench loads values just below or at a width boundary: all-ones bytes and halfwords, a negative step across zero, and non-zero upper bits above a byte or halfword that wraps to zero. A design that masked the wrong width, failed to sign-extend, or let the carry spill upward would show a wrong counter or a missing or spurious zero request. Pulse rates are counted over whole periods, and double-length strobes are flagged, so a divider off by one or a level-sensitive edge detector fails. A load is placed in the very cycle a pulse is applied, which exposes a design that lets the pulse win. Channel 3 is run with its operation disabled to show that the counter freezes and the illegal flag fires once per pulse, while a disabled ordinary channel raises nothing.

// File: rtl/ctp_pkg.sv
package ctp_pkg;

  localparam int CNT_W = 32;
  localparam int MOD_W = 8;
  localparam int NCH   = 4;

  typedef enum logic [1:0] {
    SRC_LINE = 2'd0,
    SRC_500  = 2'd1,
    SRC_2K   = 2'd2,
    SRC_EXT  = 2'd3
  } src_e;

  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_WALT = 2'd3
  } wid_e;

  function automatic logic [CNT_W-1:0] width_mask(input logic [1:0] w);
    logic [CNT_W-1:0] m;
    case (w)
      WID_BYTE: m = {{(CNT_W-8){1'b0}}, 8'hFF};
      WID_HALF: m = {{(CNT_W-16){1'b0}}, 16'hFFFF};
      default:  m = '1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ctp_tick_gen.sv
module ctp_tick_gen #(
  parameter int CLK_PER_500 = 200000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick2k_o,
  output logic tick500_o
);
  localparam int DIV_2K = CLK_PER_500 / 4;
  localparam int PW     = (DIV_2K > 1) ? $clog2(DIV_2K) : 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [1:0]    qtr_q, qtr_d;
  logic          at_end;

  always_comb begin
    at_end = (pre_q == PW'(DIV_2K - 1));
    pre_d  = at_end ? '0 : pre_q + 1'b1;
    qtr_d  = at_end ? qtr_q + 2'd1 : qtr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      qtr_q <= '0;
    end else begin
      pre_q <= pre_d;
      qtr_q <= qtr_d;
    end
  end

  assign tick2k_o  = at_end;
  assign tick500_o = at_end && (qtr_q == 2'd3);

endmodule

// File: rtl/ctp_edge_sync.sv
module ctp_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~s3_q;

endmodule

// File: rtl/ctp_channel.sv
module ctp_channel
  import ctp_pkg::*;
#(
  parameter bit FIXED_MT_ONLY = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_line_i,
  input  logic             tick500_i,
  input  logic             tick2k_i,
  input  logic             tick_ext_i,
  input  logic [1:0]       src_sel_i,
  input  logic [1:0]       width_sel_i,
  input  logic             op_mt_i,
  input  logic [MOD_W-1:0] mod_val_i,
  input  logic             load_en_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             pulse_o,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             illegal_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, step, sum, mask, upd;
  logic             zero_q, zero_d, ill_q, ill_d;
  logic             pulse, cnt_en, upd_zero;

  always_comb begin
    case (src_sel_i)
      SRC_LINE: pulse = tick_line_i;
      SRC_500:  pulse = tick500_i;
      SRC_2K:   pulse = tick2k_i;
      default:  pulse = tick_ext_i;
    endcase
  end

  always_comb begin
    step     = {{(CNT_W-MOD_W){mod_val_i[MOD_W-1]}}, mod_val_i};
    sum      = cnt_q + step;
    mask     = width_mask(width_sel_i);
    upd      = (cnt_q & ~mask) | (sum & mask);
    upd_zero = ((sum & mask) == '0);
    cnt_en   = load_en_i | (pulse & op_mt_i);
    cnt_d    = load_en_i ? load_val_i : upd;
    zero_d   = ~load_en_i & pulse & op_mt_i & upd_zero;
  end

  generate
    if (FIXED_MT_ONLY) begin : g_chk_op
      always_comb ill_d = pulse & ~op_mt_i;
    end else begin : g_no_chk
      always_comb ill_d = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      zero_q <= zero_d;
      ill_q  <= ill_d;
    end
  end

  assign pulse_o   = pulse;
  assign count_o   = cnt_q;
  assign zero_o    = zero_q;
  assign illegal_o = ill_q;

endmodule

// File: rtl/ctp_timer_unit.sv
module ctp_timer_unit
  import ctp_pkg::*;
#(
  parameter int CLK_PER_500 = 200000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_pulse_i,
  input  logic               ext_pulse_i,
  input  logic [5:0]         src_sel_i,
  input  logic [7:0]         width_sel_i,
  input  logic [3:0]         op_mt_i,
  input  logic [31:0]        mod_val_i,
  input  logic [3:0]         load_en_i,
  input  logic [127:0]       load_val_i,
  output logic [127:0]       count_o,
  output logic [3:0]         pulse_o,
  output logic [3:0]         zero_req_o,
  output logic               illegal_op_o
);
  logic tick2k, tick500, tick_line, tick_ext;
  logic [NCH-1:0] ill_v;

  ctp_tick_gen #(.CLK_PER_500(CLK_PER_500)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick2k_o (tick2k),
    .tick500_o(tick500)
  );

  ctp_edge_sync u_sync_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(line_pulse_i),
    .rise_o (tick_line)
  );

  ctp_edge_sync u_sync_ext (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(ext_pulse_i),
    .rise_o (tick_ext)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      logic [1:0] sel;
      if (g == NCH - 1) begin : g_fixed
        assign sel = SRC_500;
      end else begin : g_free
        assign sel = src_sel_i[2*g +: 2];
      end

      ctp_channel #(.FIXED_MT_ONLY(g == NCH - 1)) u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_line_i(tick_line),
        .tick500_i  (tick500),
        .tick2k_i   (tick2k),
        .tick_ext_i (tick_ext),
        .src_sel_i  (sel),
        .width_sel_i(width_sel_i[2*g +: 2]),
        .op_mt_i    (op_mt_i[g]),
        .mod_val_i  (mod_val_i[MOD_W*g +: MOD_W]),
        .load_en_i  (load_en_i[g]),
        .load_val_i (load_val_i[CNT_W*g +: CNT_W]),
        .pulse_o    (pulse_o[g]),
        .count_o    (count_o[CNT_W*g +: CNT_W]),
        .zero_o     (zero_req_o[g]),
        .illegal_o  (ill_v[g])
      );
    end
  endgenerate

  assign illegal_op_o = |ill_v;

endmodule

// File: rtl/ctp_timer_unit_chk.sv
module ctp_timer_unit_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [3:0]   op_mt_i,
  input logic [3:0]   load_en_i,
  input logic [127:0] load_val_i,
  input logic [127:0] count_o,
  input logic [3:0]   pulse_o,
  input logic [3:0]   zero_req_o,
  input logic         illegal_op_o
);
  // R2
  ch3_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o[3] |=> !pulse_o[3]);

  // R9
  illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_op_o |-> ($past(pulse_o[3]) && !$past(op_mt_i[3])));

  generate
    for (genvar i = 0; i < 4; i++) begin : g_c
      // R7
      zero_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_req_o[i] |-> ($past(pulse_o[i]) && !$past(load_en_i[i])));

      // R8
      load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load_en_i[i]) |->
          (count_o[32*i +: 32] == $past(load_val_i[32*i +: 32])) && !zero_req_o[i]);

      // R5
      hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pulse_o[i]) && !$past(load_en_i[i])) |-> $stable(count_o[32*i +: 32]));
    end
  endgenerate

endmodule

bind ctp_timer_unit ctp_timer_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_mt_i     (op_mt_i),
  .load_en_i   (load_en_i),
  .load_val_i  (load_val_i),
  .count_o     (count_o),
  .pulse_o     (pulse_o),
  .zero_req_o  (zero_req_o),
  .illegal_op_o(illegal_op_o)
);

// File: tb/sim_ctp_timer_unit.sv
`timescale 1ns/1ps
module sim_ctp_timer_unit;
  localparam int PER = 16;
  localparam int NV  = 10;

  logic         clk, rst_n, line_p, ext_p;
  logic [5:0]   src_sel;
  logic [7:0]   wsel;
  logic [3:0]   op_mt, load_en;
  logic [31:0]  modv;
  logic [127:0] load_val;
  logic [127:0] count;
  logic [3:0]   pulse, zreq;
  logic         illegal;

  int checks = 0;
  int fails  = 0;
  int pcnt [4];
  int zcnt [4];
  int dbl;
  int icnt;
  logic [3:0] pulse_prev;

  ctp_timer_unit #(.CLK_PER_500(PER)) u0 (
    .clk(clk), .rst_n(rst_n), .line_pulse_i(line_p), .ext_pulse_i(ext_p),
    .src_sel_i(src_sel), .width_sel_i(wsel), .op_mt_i(op_mt), .mod_val_i(modv),
    .load_en_i(load_en), .load_val_i(load_val), .count_o(count), .pulse_o(pulse),
    .zero_req_o(zreq), .illegal_op_o(illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {load value, width, modify, expected counter, expected zero request}
  localparam logic [74:0] VEC [NV] = '{
    {32'h0000_0001, 2'd0, 8'hFF, 32'h0000_0000, 1'b1},
    {32'h1234_5601, 2'd0, 8'hFF, 32'h1234_5600, 1'b1},
    {32'h0000_00FF, 2'd0, 8'h01, 32'h0000_0000, 1'b1},
    {32'h0000_FFFF, 2'd1, 8'h01, 32'h0000_0000, 1'b1},
    {32'h0001_00FF, 2'd1, 8'h01, 32'h0001_0100, 1'b0},
    {32'hFFFF_FFFF, 2'd2, 8'h01, 32'h0000_0000, 1'b1},
    {32'h0000_0080, 2'd0, 8'h7F, 32'h0000_00FF, 1'b0},
    {32'h0000_0005, 2'd3, 8'hFD, 32'h0000_0002, 1'b0},
    {32'h0000_0000, 2'd1, 8'hFF, 32'h0000_FFFF, 1'b0},
    {32'hABCD_0003, 2'd1, 8'hFD, 32'hABCD_0000, 1'b1}
  };

  always @(negedge clk) begin
    for (int c = 0; c < 4; c++) begin
      if (pulse[c]) pcnt[c]++;
      if (zreq[c]) zcnt[c]++;
      if (pulse[c] && pulse_prev[c]) dbl++;
    end
    if (illegal) icnt++;
    pulse_prev <= pulse;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clr();
    for (int c = 0; c < 4; c++) begin
      pcnt[c] = 0;
      zcnt[c] = 0;
    end
    dbl  = 0;
    icnt = 0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ext_rise();
    ext_p = 1'b1;
    cyc(3);
    ext_p = 1'b0;
    cyc(3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] keep, mdl;
    rst_n = 1'b0; line_p = 1'b0; ext_p = 1'b0;
    src_sel = {2'd0, 2'd0, 2'd3};
    wsel = '0; op_mt = 4'hF; modv = '0; load_en = '0; load_val = '0;
    pulse_prev = '0;
    clr();
    cyc(3);
    // R1: during reset
    chk("R1 count", count[31:0] | count[63:32] | count[95:64] | count[127:96], 32'h0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 count", count[31:0] | count[63:32] | count[95:64] | count[127:96], 32'h0);
    chk("R1 flags", {23'd0, illegal, zreq, pulse}, 32'h0);

    // R5 R6 R7: vector walk on channel 0, external source
    for (int v = 0; v < NV; v++) begin
      load_en[0] = 1'b1;
      load_val[31:0] = VEC[v][74:43];
      wsel[1:0] = VEC[v][42:41];
      modv[7:0] = VEC[v][40:33];
      cyc(1);
      load_en[0] = 1'b0;
      clr();
      ext_rise();
      chk($sformatf("R5 R6 vec%0d count", v), count[31:0], VEC[v][32:1]);
      chk($sformatf("R7 vec%0d zero", v), zcnt[0], {31'd0, VEC[v][0]});
      chk($sformatf("R4 vec%0d one pulse", v), pcnt[0], 32'd1);
    end

    // R2 R3: rates over 64 cycles
    src_sel = {2'd2, 2'd1, 2'd3};
    cyc(2);
    clr();
    cyc(64);
    chk("R3 500Hz count", pcnt[1], 32'd4);
    chk("R3 2kHz count", pcnt[2], 32'd16);
    chk("R2 ch3 count", pcnt[3], 32'd4);
    chk("R2 R3 single-cycle", dbl, 32'd0);

    // R4: line source
    src_sel = {2'd2, 2'd0, 2'd3};
    cyc(2);
    clr();
    line_p = 1'b1;
    cyc(4);
    line_p = 1'b0;
    cyc(4);
    chk("R4 line pulse", pcnt[1], 32'd1);

    // R6 on channel 3: counts +1 per pulse at word width
    wsel[7:6] = 2'd2;
    modv[31:24] = 8'h01;
    load_en[3] = 1'b1;
    load_val[127:96] = 32'h0;
    cyc(1);
    load_en[3] = 1'b0;
    mdl = 0;
    for (int k = 0; k < 64; k++) begin
      if (pulse[3]) mdl++;
      cyc(1);
    end
    chk("R6 ch3 count", count[127:96], mdl);
    chk("R2 ch3 pulses", mdl, 32'd4);

    // R9: channel 3 with operation disabled
    op_mt[3] = 1'b0;
    keep = count[127:96];
    cyc(1);
    keep = count[127:96];
    clr();
    cyc(64);
    chk("R9 illegal count", icnt, 32'd4);
    chk("R9 ch3 frozen", count[127:96], keep);
    op_mt[3] = 1'b1;

    // R9: ordinary channel disabled, no flag, no change
    op_mt[0] = 1'b0;
    keep = count[31:0];
    clr();
    ext_rise();
    chk("R9 ch0 frozen", count[31:0], keep);
    chk("R9 ch0 no zero", zcnt[0], 32'd0);
    op_mt[0] = 1'b1;

    // R8: load in the same cycle as a pulse
    wsel[1:0] = 2'd2;
    modv[7:0] = 8'hFF;
    load_en[0] = 1'b1;
    load_val[31:0] = 32'h1;
    cyc(1);
    load_en[0] = 1'b0;
    clr();
    ext_p = 1'b1;
    cyc(2);
    chk("R4 pulse timing", {31'd0, pulse[0]}, 32'd1);
    load_en[0] = 1'b1;
    load_val[31:0] = 32'h5;
    cyc(1);
    load_en[0] = 1'b0;
    ext_p = 1'b0;
    chk("R8 load wins", count[31:0], 32'h5);
    cyc(3);
    chk("R8 no zero", zcnt[0], 32'd0);

    finish_run();
  end

endmodule